// File: doc/BRIEF.md
# Buffered Five-Channel PWM Timer Bank

This block holds five down-counting timers behind a word-addressed register bus. A timer counts at the bus clock divided twice. The first division comes from one of two 8-bit prescalers: one serves timers 0 and 1, the other serves timers 2, 3 and 4. The second is a power-of-two divider that each timer selects for itself. Software writes a reload count and, for timers 0 to 2, a compare value into buffer registers. A manual-update control bit copies the buffers into the live counter. When a running timer reaches zero it reloads from the buffers if auto-reload is set. If auto-reload is clear it stops.

Timers 0 to 3 each drive one PWM pin with optional inversion. Timer 3 has no compare buffer and always compares against zero. Timer 4 is an internal time base with no pin and no compare. Each timer has a read-only observe register that shows its live counter. Each timer also has a status bit that is set on every underflow and cleared by writing 1 to it.

Top module: `pwm_timer_bank`

## Requirements
- R1: Word addresses are: 0 prescaler config, 1 divider config, 2 control, 3/4/5 reload, compare and observe of timer 0, 6/7/8 the same for timer 1, 9/10/11 for timer 2, 12 reload of timer 3, 13 reserved, 14 observe of timer 3, 15/16 reload and observe of timer 4, 17 status. The reserved word and unmapped words read as zero. Writes to the reserved word and to the observe words have no effect.
- R2: Prescaler config bits 7:0 (value P0) make timers 0 and 1 tick every P0+1 clocks. Bits 15:8 (value P1) do the same for timers 2, 3 and 4, and P0 has no effect on those timers.
- R3: Divider config bits 4n+3:4n select the extra division for timer n. Codes 0, 1, 2, 3 and 4 give 1, 2, 4, 8 and 16. Codes above 4 also give 16.
- R4: Control bit groups sit at bits 3:0 for timer 0 and at bits 4(n+1)+3:4(n+1) for timer n from 1 to 3. Within a group, from low bit to high bit, the bits are start, manual update, invert and auto-reload. Timer 4 uses bit 20 for start, bit 21 for manual update and bit 22 for auto-reload. All other control bits read as zero.
- R5: While a timer's manual-update bit is 1, its live counter and compare are reloaded from the buffers on every clock and the timer does not count.
- R6: A started timer decrements by one per timer tick. With auto-reload set it passes through the values reload down to 0, so one period is reload+1 ticks.
- R7: A started, non-inverted output is high while the counter is greater than the compare value and low otherwise.
- R8: The invert bit flips the output. A stopped timer drives its inactive level, which is 0 when not inverted and 1 when inverted.
- R9: When a started timer is at 0 on a tick, status bit n (bits 4:0) is set. Writing 1 to a status bit clears it.
- R10: Without auto-reload, a timer that underflows clears its own start bit and holds its counter at 0.
- R11: Timer 3 compares against zero. Timer 4 drives no pin, so the PWM output bus is 4 bits wide.
- R12: An observe word returns the live value of its timer's counter.
- R13: After reset, every register reads as zero and all PWM outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| pwm_out | output | 4 | PWM outputs of timers 0 to 3 |

## Verification
The bench targets the point at which counting starts after manual update is released. A design that starts one tick late, or that skips the reload value, produces a period other than reload+1. The bench also checks that prescaler groups are separated: a timer 4 that reads the wrong prescaler field ticks at the wrong rate. For one-shot timers, a design that does not clear the start bit keeps counting and wraps. A reserved word that is writable, or a timer 3 that uses that word as its compare value, shows up as changed read data or a changed duty cycle.

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [4:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic [3:0]  pwm_out
);
  localparam int NCH = 5;
  localparam int NGRP = 2;
  localparam logic [22:0] CTRL_MASK = 23'h7FFF0F;

  logic [2*PRE_W-1:0]          cfg0_q;
  logic [4*NCH-1:0]            cfg1_q;
  logic [22:0]                 ctrl_q;
  logic [NCH-1:0]              irq_q;
  logic [NGRP-1:0]             pre_tick;
  logic [NCH-1:0]              uflow, done;
  logic [NCH-1:0][CNT_W-1:0]   cnt_v, cntb_v, cmpb_v;
  logic [22:0]                 stop_vec;
  logic                        unused_wbits;

  assign unused_wbits = ^wdata[31:23];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg0_q <= '0;
      cfg1_q <= '0;
    end else if (wr_en) begin
      if (addr == 5'd0) cfg0_q <= wdata[2*PRE_W-1:0];
      if (addr == 5'd1) cfg1_q <= wdata[4*NCH-1:0];
    end

  for (genvar g = 0; g < NGRP; g++) begin : g_pre
    logic [PRE_W-1:0] pcnt;
    assign pre_tick[g] = pcnt >= cfg0_q[g*PRE_W +: PRE_W];
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)           pcnt <= '0;
      else if (pre_tick[g]) pcnt <= '0;
      else                  pcnt <= pcnt + 1'b1;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam int CB     = (ch == 0) ? 0 : 4 * (ch + 1);
    localparam int AR     = (ch == 4) ? CB + 2 : CB + 3;
    localparam int GRP    = (ch < 2) ? 0 : 1;
    localparam int CNTB_A = (ch < 4) ? 3 + 3 * ch : 15;

    logic [3:0]       dcnt, mask;
    logic             tick, run, upd, arl;
    logic [CNT_W-1:0] cntb, cnt, cmp;

    always_comb
      case (cfg1_q[4*ch +: 4])
        4'd0:    mask = 4'h0;
        4'd1:    mask = 4'h1;
        4'd2:    mask = 4'h3;
        4'd3:    mask = 4'h7;
        default: mask = 4'hF;
      endcase

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)             dcnt <= '0;
      else if (pre_tick[GRP]) dcnt <= dcnt + 1'b1;

    assign tick = pre_tick[GRP] && ((dcnt & mask) == mask);
    assign run  = ctrl_q[CB];
    assign upd  = ctrl_q[CB+1];
    assign arl  = ctrl_q[AR];
    assign uflow[ch] = run && !upd && tick && (cnt == '0);
    assign done[ch]  = uflow[ch] && !arl;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) cntb <= '0;
      else if (wr_en && addr == 5'(CNTB_A)) cntb <= wdata[CNT_W-1:0];

    if (ch < 3) begin : g_cmp
      logic [CNT_W-1:0] cmpb;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) cmpb <= '0;
        else if (wr_en && addr == 5'(4 + 3 * ch)) cmpb <= wdata[CNT_W-1:0];
      assign cmpb_v[ch] = cmpb;
    end else begin : g_nocmp
      assign cmpb_v[ch] = '0;
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt <= '0;
        cmp <= '0;
      end else if (upd) begin
        cnt <= cntb;
        cmp <= cmpb_v[ch];
      end else if (run && tick) begin
        if (cnt != '0)  cnt <= cnt - 1'b1;
        else if (arl) begin
          cnt <= cntb;
          cmp <= cmpb_v[ch];
        end
      end

    if (ch < 4) begin : g_out
      assign pwm_out[ch] = ctrl_q[CB+2] ^ (run && (cnt > cmp));
    end

    assign cnt_v[ch]  = cnt;
    assign cntb_v[ch] = cntb;
  end

  assign stop_vec = 23'(done[0]) | (23'(done[1]) << 8) | (23'(done[2]) << 12)
                  | (23'(done[3]) << 16) | (23'(done[4]) << 20);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     ctrl_q <= '0;
    else if (wr_en && addr == 5'd2) ctrl_q <= wdata[22:0] & CTRL_MASK;
    else                            ctrl_q <= ctrl_q & ~stop_vec;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq_q <= '0;
    else irq_q <= (irq_q & ~((wr_en && addr == 5'd17) ? wdata[NCH-1:0] : '0)) | uflow;

  always_comb
    case (addr)
      5'd0:  rdata = 32'(cfg0_q);
      5'd1:  rdata = 32'(cfg1_q);
      5'd2:  rdata = 32'(ctrl_q);
      5'd3:  rdata = 32'(cntb_v[0]);
      5'd4:  rdata = 32'(cmpb_v[0]);
      5'd5:  rdata = 32'(cnt_v[0]);
      5'd6:  rdata = 32'(cntb_v[1]);
      5'd7:  rdata = 32'(cmpb_v[1]);
      5'd8:  rdata = 32'(cnt_v[1]);
      5'd9:  rdata = 32'(cntb_v[2]);
      5'd10: rdata = 32'(cmpb_v[2]);
      5'd11: rdata = 32'(cnt_v[2]);
      5'd12: rdata = 32'(cntb_v[3]);
      5'd14: rdata = 32'(cnt_v[3]);
      5'd15: rdata = 32'(cntb_v[4]);
      5'd16: rdata = 32'(cnt_v[4]);
      5'd17: rdata = 32'(irq_q);
      default: rdata = '0;
    endcase
endmodule

module pwm_timer_bank_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [4:0]       addr,
  input logic [31:0]      rdata,
  input logic [3:0]       pwm_out,
  input logic [22:0]      ctrl_q,
  input logic [4:0]       irq_q,
  input logic [CNT_W-1:0] cnt0
);
  assert_idle_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[0] |-> pwm_out[0] == ctrl_q[2]);

  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    addr == 5'd13 |-> rdata == 32'd0);

  assert_irq_from_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q[0]) |-> $past(ctrl_q[0]));

  assert_stopped_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!ctrl_q[0] && !ctrl_q[1]) |-> $stable(cnt0));

  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctrl_q[0] && !ctrl_q[1] && cnt0 != '0) |-> (cnt0 == $past(cnt0) || cnt0 == $past(cnt0) - 1'b1));
endmodule

bind pwm_timer_bank pwm_timer_bank_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rdata(rdata), .pwm_out(pwm_out),
  .ctrl_q(ctrl_q), .irq_q(irq_q), .cnt0(cnt_v[0])
);

// File: tb/tb_pwm_timer_bank.sv
module tb_pwm_timer_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  pwm_out;
  int checks = 0;
  int failures = 0;

  pwm_timer_bank dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                      .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out));

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic measure(input string req, input logic [4:0] a, input int exp);
    logic [31:0] prev, cur;
    int gap;
    rd(a, prev);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); rd(a, cur);
      if (cur != prev) break;
    end
    prev = cur; gap = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); rd(a, cur); gap++;
      if (cur != prev) break;
    end
    check(req, gap, exp);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 18; a++) begin
      rd(5'(a), v);
      check("R13 reset read", v, 0);
    end
    check("R13 reset pwm", 32'(pwm_out), 0);
  endtask

  task automatic t_periodic;
    logic [31:0] v, e;
    wr(5'd3, 4); wr(5'd4, 1);
    wr(5'd2, 32'hA);
    wr(5'd2, 32'h9);
    for (int i = 0; i < 10; i++) begin
      e = 4 - (i % 5);
      rd(5'd5, v);
      check("R6 R12 observe count", v, e);
      check("R7 duty level", 32'(pwm_out[0]), 32'(e > 1));
      @(negedge clk);
    end
    wr(5'd2, 0);
    rd(5'd17, v); check("R9 status set", 32'(v[0]), 1);
    check("R8 stopped low", 32'(pwm_out[0]), 0);
    wr(5'd17, 1);
    rd(5'd17, v); check("R9 write-one clear", 32'(v[0]), 0);
    wr(5'd2, 32'h4);
    check("R8 stopped inverted high", 32'(pwm_out[0]), 1);
    rd(5'd5, e);
    wr(5'd5, 32'h1234);
    rd(5'd5, v); check("R1 observe write ignored", v, e);
  endtask

  task automatic t_oneshot;
    logic [31:0] v;
    wr(5'd6, 3);
    wr(5'd2, 32'h200);
    wr(5'd2, 32'h100);
    rd(5'd8, v); check("R6 one-shot loaded", v, 3);
    wait_cyc(6);
    rd(5'd2, v); check("R10 start cleared", 32'(v[8]), 0);
    rd(5'd8, v); check("R10 counter held at zero", v, 0);
    rd(5'd17, v); check("R9 status bit1", 32'(v[1]), 1);
    check("R10 output idle", 32'(pwm_out[1]), 0);
    wr(5'd17, 32'h1F);
  endtask

  task automatic t_update_hold;
    logic [31:0] v;
    wr(5'd9, 7);
    wr(5'd2, 32'h3000);
    wait_cyc(3);
    rd(5'd11, v); check("R5 loaded while held", v, 7);
    wait_cyc(3);
    rd(5'd11, v); check("R5 no counting while held", v, 7);
    wr(5'd9, 9);
    wait_cyc(1);
    rd(5'd11, v); check("R5 continuous reload", v, 9);
    wr(5'd2, 32'h1000);
    rd(5'd11, v); check("R6 count after release", v, 9);
    wait_cyc(1);
    rd(5'd11, v); check("R6 first decrement", v, 8);
  endtask

  task automatic t_rates;
    wr(5'd2, 0);
    wr(5'd9, 200);
    wr(5'd0, 32'h0200);
    wr(5'd1, 32'h100);
    wr(5'd2, 32'hA000);
    wr(5'd2, 32'h9000);
    measure("R2 R3 prescale 3 div 2", 5'd11, 6);
    wr(5'd2, 0);
    wr(5'd15, 200);
    wr(5'd0, 32'h0003);
    wr(5'd1, 0);
    wr(5'd2, 32'h600000);
    wr(5'd2, 32'h500000);
    measure("R2 group separation timer4", 5'd16, 1);
    wr(5'd0, 0);
    wr(5'd1, 32'h40000);
    measure("R3 div code 4", 5'd16, 16);
    wr(5'd1, 32'h70000);
    measure("R3 code above 4", 5'd16, 16);
    wr(5'd1, 32'h20000);
    measure("R3 div code 2", 5'd16, 4);
    wr(5'd2, 0);
    wr(5'd1, 0);
  endtask

  task automatic t_ch3;
    logic [31:0] v, e;
    wr(5'd12, 2);
    wr(5'd13, 32'hFFFF);
    rd(5'd13, v); check("R1 reserved reads zero", v, 0);
    wr(5'd2, 32'hA0000);
    wr(5'd2, 32'h90000);
    for (int i = 0; i < 6; i++) begin
      e = 2 - (i % 3);
      rd(5'd14, v);
      check("R11 timer3 count", v, e);
      check("R11 timer3 compares zero", 32'(pwm_out[3]), 32'(e > 0));
      @(negedge clk);
    end
    wr(5'd2, 32'h40000);
    check("R8 timer3 inverted idle", 32'(pwm_out[3]), 1);
  endtask

  task automatic t_ctrl_mask;
    logic [31:0] v;
    wr(5'd2, 32'h00F000F0);
    rd(5'd2, v); check("R4 control bit packing", v, 32'h00700000);
    wr(5'd2, 0);
    rd(5'd2, v); check("R4 control cleared", v, 0);
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL all-R watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    t_reset();
    t_periodic();
    t_oneshot();
    t_update_hold();
    t_rates();
    t_ch3();
    t_ctrl_mask();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule